// File: doc/BRIEF.md
# Presettable Synchronous Counter with Carry

This block is a small up-counter. Its state changes on the rising clock edge. It can be preset from a parallel data word, cleared, advanced, or held. Two count-enable inputs must both be high for the counter to advance, and each has its own role. The first, `enp_i`, only allows counting. The second, `ent_i`, also gates the carry output. Wide counters are built by chaining stages: the carry of one stage drives `ent_i` of the next. The low-order stage takes the global count enable on `enp_i`.

Two parameters set the variant, and both are fixed at elaboration:

- `DECADE` chooses between binary (modulo 2^WIDTH) and decade (modulo 10) counting.
- `ASYNC_CLR` chooses how the clear acts. When set, the clear forces zero at once. When cleared, the clear acts at the next clock edge, so logic that decodes a chosen count onto the clear input shortens the count cycle.

The `rst_ni` input is an asynchronous reset that puts the counter at zero in either mode.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0, whatever the clock and the other inputs.
- R2: When `load_ni` is low and the clear is inactive, `q_o` takes the value of `d_i` at the next rising edge, whatever the levels of `enp_i` and `ent_i`.
- R3: When the clear and the load are inactive and both `enp_i` and `ent_i` are high, `q_o` advances by one at each rising edge. In binary mode the count wraps from 15 to 0.
- R4: When the clear and the load are inactive and either enable is low, `q_o` keeps its value across rising edges.
- R5: `rco_o` is 1 exactly when `ent_i` is 1 and `q_o` is at the terminal count (15 in binary mode, 9 in decade mode). It does not depend on `enp_i`.
- R6: With `ASYNC_CLR`=1, `clr_ni` low forces `q_o` to 0 without waiting for a clock edge, and `q_o` stays 0 while `clr_ni` is low.
- R7: With `ASYNC_CLR`=0, `clr_ni` low has no effect between edges. It sets `q_o` to 0 at the next rising edge, overriding the load and both enables.
- R8: Priority from highest to lowest is clear, load, count, hold.
- R9: In decade mode, counting steps 9 to 0, so after a preset to 7 the count runs 8, 9, 0, 1, 2, 3.
- R10: In decade mode, a loaded value above 9 advances by one modulo 16 (10..14 go to the next value, 15 goes to 0) and then follows the decade sequence.
- R11: Changes on `load_ni`, `enp_i`, `ent_i` or `d_i` between rising edges leave `q_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset to zero, active low |
| clr_ni | input | 1 | Counter clear, active low; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_ni | input | 1 | Parallel preset, active low, synchronous |
| enp_i | input | 1 | Count enable that does not gate the carry |
| ent_i | input | 1 | Count enable that also gates `rco_o` |
| d_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Current count |
| rco_o | output | 1 | Carry out: high at terminal count while `ent_i` is high |

## Verification
The bench checks each corner case below and what a faulty design would show:

- **Binary wrap.** A preset of 12 counts through 15 to 0. A design that saturates at 15 would stall there.
- **Decade wrap.** A preset of 7 counts 8, 9, 0. A binary step here would show 10 after 9.
- **Out-of-range decade value.** A load of 12 in decade mode must go 13, 14, 15, 0. A design that treats every value above 9 as terminal would jump to 0 early, and a missing modulo would lock the count up.
- **Carry gating.** The carry is checked at the terminal count with `ent_i` low (must be low) and with only `enp_i` low (must stay high). This catches a carry gated by the wrong enable.
- **Clear timing.** The clear is sampled mid-cycle in both modes. The synchronous variant must not move before the edge, and the asynchronous one must not wait for it.
- **Priority.** Clear against load, and load against count, are each driven in the same cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  function automatic int term_count(input int width, input bit decade);
    return decade ? 9 : (1 << width) - 1;
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    enp_i,
  input  logic    ent_i,
  output cnt_op_e op_o
);

  always_comb begin
    if (!clr_ni)             op_o = OP_CLEAR;
    else if (!load_ni)       op_o = OP_LOAD;
    else if (enp_i && ent_i) op_o = OP_COUNT;
    else                     op_o = OP_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] d_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam int TC = term_count(WIDTH, DECADE);
  localparam logic [WIDTH-1:0] TC_V = TC[WIDTH-1:0];

  logic [WIDTH-1:0] step;

  generate
    if (DECADE) begin : g_dec
      // only the exact terminal value wraps; larger values step on modulo 2^WIDTH
      always_comb step = (q_i == TC_V) ? '0 : q_i + 1'b1;
    end else begin : g_bin
      always_comb step = q_i + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = d_i;
      OP_COUNT: nxt_o = step;
      default:  nxt_o = q_i;
    endcase
  end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int WIDTH = 4,
  parameter int TC    = 15
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             ent_i,
  output logic             rco_o
);

  localparam logic [WIDTH-1:0] TC_V = TC[WIDTH-1:0];

  assign rco_o = ent_i & (q_i == TC_V);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             enp_i,
  input  logic             ent_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             rco_o
);

  localparam int TC = term_count(WIDTH, DECADE);

  cnt_op_e          op;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl u_ctrl (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .enp_i   (enp_i),
    .ent_i   (ent_i),
    .op_o    (op)
  );

  cnt_next #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
  ) u_next (
    .q_i   (q_q),
    .d_i   (d_i),
    .op_i  (op),
    .nxt_o (nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      logic arst_n;
      assign arst_n = rst_ni & clr_ni;
      always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) q_q <= '0;
        else         q_q <= nxt;
      end
    end else begin : g_sclr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= nxt;
      end
    end
  endgenerate

  cnt_carry #(
    .WIDTH (WIDTH),
    .TC    (TC)
  ) u_carry (
    .q_i   (q_q),
    .ent_i (ent_i),
    .rco_o (rco_o)
  );

  assign q_o = q_q;

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             enp_i,
  input logic             ent_i,
  input logic [WIDTH-1:0] d_i,
  input logic [WIDTH-1:0] q_o,
  input logic             rco_o
);

  localparam int TC = term_count(WIDTH, DECADE);
  localparam logic [WIDTH-1:0] TC_V = TC[WIDTH-1:0];

  AST_LOAD_TAKES_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (!clr_ni || q_o == $past(d_i)));  // R2

  AST_COUNT_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && enp_i && ent_i) |=>
      (!clr_ni || q_o == (($past(q_o) == TC_V) ? '0 : $past(q_o) + 1'b1)));  // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(enp_i && ent_i)) |=> (!clr_ni || $stable(q_o)));  // R4

  AST_CARRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rco_o |-> (ent_i && q_o == TC_V));  // R5

  AST_CARRY_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_i && q_o == TC_V) |-> rco_o);  // R5

  generate
    if (ASYNC_CLR) begin : g_achk
      AST_ACLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |-> (q_o == '0));  // R6
    end else begin : g_schk
      AST_SCLR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |=> (q_o == '0));  // R7
    end
  endgenerate

endmodule

bind presettable_counter presettable_counter_chk #(
  .WIDTH     (WIDTH),
  .DECADE    (DECADE),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .load_ni (load_ni),
  .enp_i   (enp_i),
  .ent_i   (ent_i),
  .d_i     (d_i),
  .q_o     (q_o),
  .rco_o   (rco_o)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_a = 1'b1;
  logic       clr_s = 1'b1;
  logic       load_n = 1'b1;
  logic       enp = 1'b0;
  logic       ent = 1'b0;
  logic [3:0] d = '0;
  logic [3:0] q_b, q_d;
  logic       rco_b, rco_d;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // binary, asynchronous clear
  presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_a), .load_ni(load_n),
    .enp_i(enp), .ent_i(ent), .d_i(d), .q_o(q_b), .rco_o(rco_b)
  );

  // decade, synchronous clear
  presettable_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dut_dec (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_s), .load_ni(load_n),
    .enp_i(enp), .ent_i(ent), .d_i(d), .q_o(q_d), .rco_o(rco_d)
  );

  typedef struct packed {
    logic       clr_n;
    logic       ld_n;
    logic       p;
    logic       t;
    logic [3:0] din;
    logic [3:0] exp_q;
    logic       exp_rco;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd12, 4'd12, 1'b0},  // R2 preset
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},  // R3 R5
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R3 wrap
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},  // R3
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd2,  1'b0},  // R3
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd2,  1'b0},  // R4 enp low
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd2,  1'b0},  // R4 ent low
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 4'd15, 1'b0},  // R2 R5 ent low masks carry
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1},  // R4 R5 carry without enp
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd5,  4'd5,  1'b0},  // R8 load over count
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  4'd0,  1'b0},  // R8 clear over load
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0}   // R3
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic dec_step(input string tag, input int exp_q, input int exp_rco);
    tick();
    check(tag, q_d, exp_q);
    check({tag, " carry"}, rco_d, exp_rco);
  endtask

  initial begin
    #2;
    check("R1 reset q", q_b, 0);
    check("R1 reset q decade", q_d, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clr_a  = VEC[i].clr_n;
      load_n = VEC[i].ld_n;
      enp    = VEC[i].p;
      ent    = VEC[i].t;
      d      = VEC[i].din;
      tick();
      check($sformatf("table row %0d q (R2 R3 R4 R8)", i), q_b, VEC[i].exp_q);
      check($sformatf("table row %0d carry (R5)", i), rco_b, VEC[i].exp_rco);
    end
    // dut q = 1 here

    // R11: mid-cycle control changes do nothing until the edge
    @(negedge clk);
    enp = 1'b1; ent = 1'b1; load_n = 1'b0; d = 4'd9;
    #3;
    check("R11 no change before edge", q_b, 1);
    load_n = 1'b1; enp = 1'b0; ent = 1'b0;
    tick();
    check("R11 hold after reverted controls", q_b, 1);

    // R6: asynchronous clear acts at once
    @(negedge clk);
    load_n = 1'b0; d = 4'd10;
    tick();
    check("R2 load 10", q_b, 10);
    @(negedge clk);
    load_n = 1'b1;
    #2;
    clr_a = 1'b0;
    #2;
    check("R6 immediate clear", q_b, 0);
    tick();
    check("R6 held at zero", q_b, 0);
    @(negedge clk);
    clr_a = 1'b1;

    // R7: synchronous clear waits for the edge, overrides count
    @(negedge clk);
    load_n = 1'b0; d = 4'd5;
    tick();
    check("R2 decade load 5", q_d, 5);
    @(negedge clk);
    load_n = 1'b1; enp = 1'b1; ent = 1'b1; clr_s = 1'b0;
    #3;
    check("R7 no clear before edge", q_d, 5);
    tick();
    check("R7 clear at edge", q_d, 0);
    @(negedge clk);
    load_n = 1'b0; d = 4'd6;  // clear still low
    tick();
    check("R8 sync clear over load", q_d, 0);
    @(negedge clk);
    clr_s = 1'b1;

    // R9: decade sequence from 7
    d = 4'd7;
    tick();
    check("R9 decade preset 7", q_d, 7);
    @(negedge clk);
    load_n = 1'b1;
    dec_step("R9 step 8", 8, 0);
    dec_step("R9 step 9", 9, 1);
    dec_step("R9 wrap 0", 0, 0);
    dec_step("R9 step 1", 1, 0);
    dec_step("R9 step 2", 2, 0);
    dec_step("R9 step 3", 3, 0);

    // R10: out-of-range decade value recovers
    @(negedge clk);
    load_n = 1'b0; d = 4'd12;
    tick();
    check("R10 load 12", q_d, 12);
    @(negedge clk);
    load_n = 1'b1;
    dec_step("R10 step 13", 13, 0);
    dec_step("R10 step 14", 14, 0);
    dec_step("R10 step 15 no carry", 15, 0);
    dec_step("R10 step 0", 0, 0);
    dec_step("R10 step 1", 1, 0);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #2;
    check("R1 mid-run reset", q_b, 0);
    check("R1 mid-run reset decade", q_d, 0);
    tick();
    check("R1 reset holds over edge", q_d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule